// File: doc/BRIEF.md
# Temperature limit alarm comparator

This block watches a stream of signed 16-bit temperature samples and compares each one with three programmable limits: a critical limit, an upper limit and a lower limit. Each limit drives an event flag. A flag sets as soon as a sample lies beyond its limit. It stays set until a later sample comes back past the limit moved inward by a programmable hysteresis. The critical flag drives a dedicated alarm output. The upper and lower flags together drive an interrupt output.

The block also forms the temperature word that software reads. In 13-bit mode the three least significant bits of that word carry the event flags. In 16-bit mode the word is the full sample, so those bits give finer resolution. Work happens only on a sample-valid strobe. Between strobes every output keeps its value. The surrounding register file holds the limits and the hysteresis, and resets them to 147, 64 and 10 degrees and 5 degrees. One degree is 128 LSBs of the sample.

Top module: `temp_limit_alarm`

## Requirements
- R1: After a synchronous active-low reset, `crit_alarm`, `irq` and `temp_word` are all 0.
- R2: On a strobe whose sample is greater than `lim_crit` (signed compare), `crit_alarm` is 1 from the next clock edge.
- R3: On a strobe whose sample is greater than `lim_high` (signed), the upper flag sets and `irq` is 1 from the next clock edge.
- R4: On a strobe whose sample is less than `lim_low` (signed, so a negative sample is below a positive limit), the lower flag sets and `irq` is 1 from the next clock edge.
- R5: A set critical or upper flag stays set while strobed samples are at or above the limit minus `hyst`×128. It clears on the first strobe with a sample below that value.
- R6: A set lower flag stays set while strobed samples are at or below `lim_low` plus `hyst`×128. It clears on the first strobe with a sample above that value.
- R7: A sample exactly equal to a limit does not set that limit's flag.
- R8: With `res16`=0 at the strobe, `temp_word` = {sample[15:3], critical flag, upper flag, lower flag}. Bit 2 is critical, bit 1 is upper and bit 0 is lower, each using the flag value after this strobe.
- R9: With `res16`=1 at the strobe, `temp_word` equals the full 16-bit sample.
- R10: Without a strobe, `crit_alarm`, `irq` and `temp_word` keep their values whatever the other inputs do.
- R11: Each hysteresis-adjusted threshold is computed without 16-bit wraparound. A threshold that lies beyond the 16-bit range still compares correctly against samples at the ends of that range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_vld | input | 1 | Strobe: a new sample is present this cycle |
| sample | input | 16 | Temperature sample, two's complement, 128 LSB per degree |
| res16 | input | 1 | Word format: 0 = flags in bits 2:0, 1 = full resolution |
| lim_crit | input | 16 | Critical limit, two's complement |
| lim_high | input | 16 | Upper limit, two's complement |
| lim_low | input | 16 | Lower limit, two's complement |
| hyst | input | 4 | Hysteresis in whole degrees, unsigned |
| crit_alarm | output | 1 | Critical event flag |
| irq | output | 1 | Upper or lower event flag |
| temp_word | output | 16 | Readable temperature word |

## Verification
Sample sequences walk each flag in steps around its threshold. A sample equal to the limit separates a strict compare from a non-strict one. A sample inside the hysteresis band separates a latching flag from a plain compare. A sample one LSB beyond the adjusted threshold shows that the band is scaled by 128. Negative samples against a positive lower limit show that the compares are signed.

Alternating `res16` shows which bits carry flags and which carry the sample. Limits placed near +32767 and -32768 with the largest hysteresis detect a threshold that wraps around.

// File: rtl/tla_pkg.sv
// Package: shared widths and constants for the temperature limit alarm.
// Assumes a 16-bit two's complement sample with 7 fractional bits.
package tla_pkg;
    localparam int TEMP_W    = 16;
    localparam int HYST_W    = 4;
    localparam int FRAC_BITS = 7;
    localparam int NUM_EV    = 3;

    // Event index doubles as the bit position in the 13-bit word.
    localparam int EV_LOW  = 0;
    localparam int EV_HIGH = 1;
    localparam int EV_CRIT = 2;

    // Register-file reset values, for the surrounding logic and the bench.
    localparam logic [TEMP_W-1:0] RST_LIM_CRIT = 16'h4980;
    localparam logic [TEMP_W-1:0] RST_LIM_HIGH = 16'h2000;
    localparam logic [TEMP_W-1:0] RST_LIM_LOW  = 16'h0500;
    localparam logic [HYST_W-1:0] RST_HYST     = 4'd5;
endpackage

// File: rtl/tla_hyst_scale.sv
// Module: tla_hyst_scale
// Turns a whole-degree hysteresis into sample LSBs, one bit wider than
// the sample so that later adds and subtracts cannot wrap.
// Assumes TW+1 >= HW+FRAC.
module tla_hyst_scale #(
    parameter int TW   = 16,
    parameter int HW   = 4,
    parameter int FRAC = 7
) (
    input  logic [HW-1:0]        hyst,
    output logic signed [TW:0]   hyst_x
);
    localparam int PADW = TW + 1 - HW - FRAC;

    // Purpose: zero-extend and scale the hysteresis by 2**FRAC.
    always_comb begin
        hyst_x = $signed({{PADW{1'b0}}, hyst, {FRAC{1'b0}}});
    end
endmodule

// File: rtl/tla_event.sv
// Module: tla_event
// One latching limit event with hysteresis. With IS_UPPER=1 it trips
// above the limit and releases below limit-hyst. Otherwise it trips
// below the limit and releases above limit+hyst. It updates only on upd.
// Assumes hyst_x is non-negative and already scaled.
module tla_event #(
    parameter int TW       = 16,
    parameter bit IS_UPPER = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic [TW-1:0]        temp,
    input  logic [TW-1:0]        limit,
    input  logic signed [TW:0]   hyst_x,
    output logic                 flag_d,
    output logic                 flag_q
);
    logic signed [TW:0] temp_x;
    logic signed [TW:0] lim_x;
    logic signed [TW:0] rel_x;
    logic               trip;
    logic               keep;

    // Purpose: sign-extend the operands to TW+1 bits.
    always_comb begin
        temp_x = $signed({temp[TW-1], temp});
        lim_x  = $signed({limit[TW-1], limit});
    end

    generate
        if (IS_UPPER) begin : g_upper
            // Purpose: over-limit trip and release threshold below the limit.
            always_comb begin
                rel_x = lim_x - hyst_x;
                trip  = temp_x > lim_x;
                keep  = temp_x >= rel_x;
            end
        end else begin : g_lower
            // Purpose: under-limit trip and release threshold above the limit.
            always_comb begin
                rel_x = lim_x + hyst_x;
                trip  = temp_x < lim_x;
                keep  = temp_x <= rel_x;
            end
        end
    endgenerate

    // Purpose: next flag value for a strobe this cycle.
    always_comb begin
        flag_d = upd ? (trip | (flag_q & keep)) : flag_q;
    end

    // Purpose: hold the flag between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end
endmodule

// File: rtl/tla_word_fmt.sv
// Module: tla_word_fmt
// Captures the readable temperature word on each strobe. In narrow mode
// the low NF bits are replaced by the event flags. In wide mode the word
// is the full sample.
module tla_word_fmt #(
    parameter int TW = 16,
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic          res16,
    input  logic [TW-1:0] temp,
    input  logic [NF-1:0] flags_d,
    output logic [TW-1:0] word_q
);
    logic [TW-1:0] word_d;

    // Purpose: choose between flag bits and sample bits at the bottom.
    always_comb begin
        word_d = res16 ? temp : {temp[TW-1:NF], flags_d};
    end

    // Purpose: register the word on a strobe, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)   word_q <= '0;
        else if (upd) word_q <= word_d;
    end
endmodule

// File: rtl/temp_limit_alarm.sv
// Module: temp_limit_alarm (top)
// Compares each strobed sample with the critical, upper and lower limits,
// each with latching hysteresis. Drives the critical alarm and the
// interrupt, and forms the readable temperature word.
// Assumes the limits and hysteresis are stable around each strobe.
module temp_limit_alarm
    import tla_pkg::*;
#(
    parameter int TEMP_W_P = TEMP_W,
    parameter int HYST_W_P = HYST_W,
    parameter int FRAC_P   = FRAC_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_vld,
    input  logic [TEMP_W_P-1:0]  sample,
    input  logic                 res16,
    input  logic [TEMP_W_P-1:0]  lim_crit,
    input  logic [TEMP_W_P-1:0]  lim_high,
    input  logic [TEMP_W_P-1:0]  lim_low,
    input  logic [HYST_W_P-1:0]  hyst,
    output logic                 crit_alarm,
    output logic                 irq,
    output logic [TEMP_W_P-1:0]  temp_word
);
    logic signed [TEMP_W_P:0]            hyst_x;
    logic [NUM_EV-1:0][TEMP_W_P-1:0]     lim_arr;
    logic [NUM_EV-1:0]                   ev_d;
    logic [NUM_EV-1:0]                   ev_q;

    // Purpose: collect the limits by event index.
    always_comb begin
        lim_arr[EV_CRIT] = lim_crit;
        lim_arr[EV_HIGH] = lim_high;
        lim_arr[EV_LOW]  = lim_low;
    end

    tla_hyst_scale #(.TW(TEMP_W_P), .HW(HYST_W_P), .FRAC(FRAC_P)) u_scale (
        .hyst   (hyst),
        .hyst_x (hyst_x)
    );

    generate
        for (genvar gi = 0; gi < NUM_EV; gi++) begin : g_ev
            tla_event #(.TW(TEMP_W_P), .IS_UPPER(gi != EV_LOW)) u_ev (
                .clk    (clk),
                .rst_n  (rst_n),
                .upd    (sample_vld),
                .temp   (sample),
                .limit  (lim_arr[gi]),
                .hyst_x (hyst_x),
                .flag_d (ev_d[gi]),
                .flag_q (ev_q[gi])
            );
        end
    endgenerate

    tla_word_fmt #(.TW(TEMP_W_P), .NF(NUM_EV)) u_word (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (sample_vld),
        .res16   (res16),
        .temp    (sample),
        .flags_d (ev_d),
        .word_q  (temp_word)
    );

    // Purpose: map the event flags onto the two alarm outputs.
    always_comb begin
        crit_alarm = ev_q[EV_CRIT];
        irq        = ev_q[EV_HIGH] | ev_q[EV_LOW];
    end
endmodule

// File: rtl/tla_alarm_chk.sv
// Module: tla_alarm_chk
// Port-level properties of temp_limit_alarm, attached with bind below.
module tla_alarm_chk #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sample_vld,
    input logic [TW-1:0] sample,
    input logic          res16,
    input logic [TW-1:0] lim_crit,
    input logic [TW-1:0] lim_high,
    input logic [TW-1:0] lim_low,
    input logic          crit_alarm,
    input logic          irq,
    input logic [TW-1:0] temp_word
);
    a_r2_crit_set: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld && ($signed(sample) > $signed(lim_crit)) |=> crit_alarm);

    a_r3_high_set: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld && ($signed(sample) > $signed(lim_high)) |=> irq);

    a_r4_low_set: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld && ($signed(sample) < $signed(lim_low)) |=> irq);

    // R5/R7: an idle critical flag does not set at or below the limit
    a_r7_crit_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld && !crit_alarm && ($signed(sample) <= $signed(lim_crit))
        |=> !crit_alarm);

    a_r8_narrow_word: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld && !res16 |=>
        (temp_word[TW-1:3] == $past(sample[TW-1:3])) && (temp_word[2] == crit_alarm));

    a_r9_wide_word: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld && res16 |=> temp_word == $past(sample));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> $stable(crit_alarm) && $stable(irq) && $stable(temp_word));
endmodule

bind temp_limit_alarm tla_alarm_chk #(.TW(TEMP_W_P)) u_alarm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_vld (sample_vld),
    .sample     (sample),
    .res16      (res16),
    .lim_crit   (lim_crit),
    .lim_high   (lim_high),
    .lim_low    (lim_low),
    .crit_alarm (crit_alarm),
    .irq        (irq),
    .temp_word  (temp_word)
);

// File: tb/temp_limit_alarm_tb_top.sv
// Bench: directed scenarios, one task each, expected values from the brief.
module temp_limit_alarm_tb_top;
    import tla_pkg::*;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_vld = 1'b0;
    logic [15:0] sample = '0;
    logic        res16 = 1'b0;
    logic [15:0] lim_crit = RST_LIM_CRIT;
    logic [15:0] lim_high = RST_LIM_HIGH;
    logic [15:0] lim_low  = RST_LIM_LOW;
    logic [3:0]  hyst     = RST_HYST;
    logic        crit_alarm;
    logic        irq;
    logic [15:0] temp_word;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    temp_limit_alarm dut_i (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .sample(sample),
        .res16(res16), .lim_crit(lim_crit), .lim_high(lim_high),
        .lim_low(lim_low), .hyst(hyst), .crit_alarm(crit_alarm),
        .irq(irq), .temp_word(temp_word)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic c, input logic i, input logic [15:0] w);
        check({req, " crit_alarm"}, {15'd0, crit_alarm}, {15'd0, c});
        check({req, " irq"}, {15'd0, irq}, {15'd0, i});
        check({req, " temp_word"}, temp_word, w);
    endtask

    // Drive one strobe at a falling edge. Outputs change at the next rising
    // edge and are sampled at the falling edge after it.
    task automatic strobe(input logic [15:0] s, input logic r);
        @(negedge clk);
        sample = s; res16 = r; sample_vld = 1'b1;
        @(negedge clk);
        sample_vld = 1'b0;
    endtask

    task automatic t_reset();
        check_out("R1 reset", 1'b0, 1'b0, 16'h0000);
    endtask

    task automatic t_high();
        strobe(16'h1000, 1'b0); check_out("R8 quiet", 1'b0, 1'b0, 16'h1000);
        strobe(16'h2000, 1'b0); check_out("R7 equal high", 1'b0, 1'b0, 16'h2000);
        strobe(16'h2080, 1'b0); check_out("R3 above high", 1'b0, 1'b1, 16'h2082);
        strobe(16'h1E00, 1'b0); check_out("R5 inside band", 1'b0, 1'b1, 16'h1E02);
        strobe(16'h1D80, 1'b0); check_out("R5 at threshold", 1'b0, 1'b1, 16'h1D82);
        strobe(16'h1D7F, 1'b0); check_out("R5 high release", 1'b0, 1'b0, 16'h1D78);
    endtask

    task automatic t_crit();
        strobe(16'h4980, 1'b0); check_out("R7 equal crit", 1'b0, 1'b1, 16'h4982);
        strobe(16'h4A00, 1'b0); check_out("R2 above crit", 1'b1, 1'b1, 16'h4A06);
        strobe(16'h4800, 1'b0); check_out("R5 crit band", 1'b1, 1'b1, 16'h4806);
        strobe(16'h4680, 1'b0); check_out("R5 crit release", 1'b0, 1'b1, 16'h4682);
        strobe(16'h1000, 1'b0); check_out("R5 all clear", 1'b0, 1'b0, 16'h1000);
    endtask

    task automatic t_low();
        strobe(16'h0500, 1'b0); check_out("R7 equal low", 1'b0, 1'b0, 16'h0500);
        strobe(16'h0400, 1'b0); check_out("R4 below low", 1'b0, 1'b1, 16'h0401);
        strobe(16'h0780, 1'b0); check_out("R6 at threshold", 1'b0, 1'b1, 16'h0781);
        strobe(16'h0781, 1'b0); check_out("R6 low release", 1'b0, 1'b0, 16'h0780);
        strobe(16'hF000, 1'b0); check_out("R4 negative sample", 1'b0, 1'b1, 16'hF001);
    endtask

    task automatic t_wide();
        strobe(16'hF00F, 1'b1); check_out("R9 wide negative", 1'b0, 1'b1, 16'hF00F);
        strobe(16'h1235, 1'b1); check_out("R9 wide positive", 1'b0, 1'b0, 16'h1235);
        strobe(16'h2087, 1'b0); check_out("R8 narrow after wide", 1'b0, 1'b1, 16'h2082);
        strobe(16'h1235, 1'b1); check_out("R9 wide release", 1'b0, 1'b0, 16'h1235);
    endtask

    task automatic t_hold();
        @(negedge clk);
        sample = 16'h7FFF; res16 = 1'b0; lim_low = 16'h7F00;
        repeat (3) @(negedge clk);
        check_out("R10 no strobe", 1'b0, 1'b0, 16'h1235);
        lim_low = RST_LIM_LOW;
    endtask

    task automatic t_range();
        hyst = 4'd15;
        lim_crit = 16'h8100; lim_high = 16'h7FFF; lim_low = 16'h8000;
        strobe(16'h8200, 1'b0); check_out("R11 crit near min", 1'b1, 1'b0, 16'h8204);
        strobe(16'h8000, 1'b0); check_out("R11 crit held at min", 1'b1, 1'b0, 16'h8004);
        lim_crit = 16'h7FFF;
        strobe(16'h0000, 1'b0); check_out("R11 crit cleared", 1'b0, 1'b0, 16'h0000);
        lim_low = 16'h7F00;
        strobe(16'h7E00, 1'b0); check_out("R11 low near max", 1'b0, 1'b1, 16'h7E01);
        strobe(16'h7FFF, 1'b0); check_out("R11 low held at max", 1'b0, 1'b1, 16'h7FF9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_high();
        t_crit();
        t_low();
        t_wide();
        t_hold();
        t_range();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule